// File: doc/BRIEF.md
# Flash Write-Strobe Bus Interface

This block is a clocked slave that connects an asynchronous 32-bit processor expansion bus to a parallel flash module. It passes each selected bus cycle straight through to the flash. It derives the flash write-enable and output-enable strobes from the address strobe, the data strobe, the read/write line and a card-select that is decoded elsewhere. It also returns a size-acknowledge pair that tells the bus the port is 32 bits wide.

All bus inputs go through a two-flop synchronizer. Every strobe edge falls on a clock edge, so it can be placed with a known margin:
- Write-enable falls one register stage after the synchronized address strobe is seen.
- Write-enable rises a fixed number of clocks after the synchronized data strobe is seen. That number is `WAIT_STATES`.
- A floor of `MIN_WE_CLKS` low clocks keeps the pulse wide enough even when the data strobe arrives early.

Write-enable returns high while the address strobe, the address and the write data are still held. This leaves data and address hold margin. When the cycle ends, the acknowledge pair is driven high for one clock and then its output enable drops, so the external buffer floats the lines.

Top module: `flash_strobe_if`

## Requirements
- R1: A cycle whose synchronized select is low at the start produces no strobe and no acknowledge. `we_no` and `oe_no` stay 1 and `dsack_oe_o` stays 0.
- R2: `we_no` and `oe_no` are never both 0. Writes (`rw_i`=0) use only `we_no`. Reads (`rw_i`=1) use only `oe_no`.
- R3: The selected strobe goes low on the third rising clock edge after `as_ni` goes low. That is two synchronizer stages plus one register.
- R4: Let d be the number of clocks from the fall of `as_ni` to the fall of `ds_ni`. The strobe phase then lasts max(d+WAIT_STATES, MIN_WE_CLKS) clocks. On the edge that ends it, `we_no` returns to 1 for a write.
- R5: Take a 125 MHz clock with WAIT_STATES=4 and MIN_WE_CLKS=8, with write data valid from the fall of `ds_ni` until the rise of `as_ni`. Under those conditions:
  - the write pulse is at least 60 ns long;
  - data setup to the `we_no` rise is at least 50 ns;
  - data hold after the `we_no` rise is at least 10 ns;
  - address hold after the `we_no` fall is at least 50 ns.
- R6: The acknowledge is asserted on the same edge that ends the strobe phase. It appears as `dsack_no`=2'b00 with `dsack_oe_o`=1 and stays until the address strobe is seen high.
- R7: On the third rising edge after `as_ni` rises, `dsack_no`=2'b11 is driven with `dsack_oe_o`=1 for exactly one clock. After that, `dsack_oe_o`=0.
- R8: If `as_ni` rises before the acknowledge, the strobe returns high on the third rising edge after that rise. The one-clock precharge of R7 follows.
- R9: For a read, `oe_no` stays 0 through the acknowledge. It returns to 1 together with the start of the precharge.
- R10: During reset, `we_no`=1, `oe_no`=1 and `dsack_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Bus address strobe, active low |
| ds_ni | input | 1 | Bus data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| sel_i | input | 1 | Decoded card select, active high |
| we_no | output | 1 | Flash write-enable, active low |
| oe_no | output | 1 | Flash output-enable, active low |
| dsack_no | output | 2 | Size acknowledge pair, 2'b00 = 32-bit port |
| dsack_oe_o | output | 1 | Drive enable for the acknowledge pair; 0 = high impedance |

## Verification
Every result lands a fixed number of clocks after the bus edge that causes it:
- The strobe falls three edges after the address strobe.
- The acknowledge follows after max(d+WAIT_STATES, MIN_WE_CLKS) further clocks.
- The precharge comes three edges after the address strobe rises, and the release one clock later.

The bench drives bus edges on falling clock edges and counts falling edges from that drive. Each expectation is checked at exactly the count the arithmetic gives, and the neighbouring counts are checked to hold the previous value. Pulse width, setup and hold are measured in nanoseconds from the recorded edge times.

// File: rtl/flash_strobe_pkg.sv
package flash_strobe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOW    = 2'd1,
    ST_ACK    = 2'd2,
    ST_PRECHG = 2'd3
  } cyc_st_e;
endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fs_cycle_fsm.sv
module fs_cycle_fsm
  import flash_strobe_pkg::*;
#(
  parameter int WAIT_STATES = 0,
  parameter int MIN_WE_CLKS = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    as_i,
  input  logic    ds_i,
  input  logic    rw_i,
  input  logic    sel_i,
  output cyc_st_e st_o,
  output cyc_st_e nxt_o,
  output logic    nxt_rd_o
);
  localparam int WS_W   = $clog2(WAIT_STATES + 2);
  localparam int LOW_W  = $clog2(MIN_WE_CLKS + 2);
  localparam logic [WS_W-1:0]  WS_MAX  = WS_W'(WAIT_STATES);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(MIN_WE_CLKS);
  localparam logic [LOW_W-1:0] LOW_MIN = LOW_W'((MIN_WE_CLKS > 0) ? MIN_WE_CLKS - 1 : 0);

  cyc_st_e st_q, nxt;
  logic    rd_q;
  logic [WS_W-1:0]  ws_cnt_q;
  logic [LOW_W-1:0] low_cnt_q;
  logic release_ok;

  // data strobe seen, wait states spent, minimum low time reached
  assign release_ok = ds_i && (ws_cnt_q == WS_MAX) && (low_cnt_q >= LOW_MIN);

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      ST_IDLE:   if (as_i && sel_i) nxt = ST_LOW;
      ST_LOW:    if (!as_i) nxt = ST_PRECHG;
                 else if (release_ok) nxt = ST_ACK;
      ST_ACK:    if (!as_i) nxt = ST_PRECHG;
      ST_PRECHG: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      rd_q      <= 1'b0;
      ws_cnt_q  <= '0;
      low_cnt_q <= '0;
    end else begin
      st_q <= nxt;
      if (st_q == ST_IDLE) rd_q <= rw_i;
      if (st_q != ST_LOW) begin
        ws_cnt_q  <= '0;
        low_cnt_q <= '0;
      end else begin
        if (ds_i && ws_cnt_q != WS_MAX)  ws_cnt_q  <= ws_cnt_q + 1'b1;
        if (low_cnt_q != LOW_MAX)        low_cnt_q <= low_cnt_q + 1'b1;
      end
    end
  end

  assign st_o     = st_q;
  assign nxt_o    = nxt;
  assign nxt_rd_o = (st_q == ST_IDLE) ? rw_i : rd_q;

  p_unsel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !sel_i) |=> (st_q != ST_LOW));

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_i && (st_q == ST_LOW || st_q == ST_ACK)) |=> (st_q == ST_PRECHG));

  p_prechg_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRECHG) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/fs_strobe_out.sv
module fs_strobe_out
  import flash_strobe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cyc_st_e    nxt_i,
  input  logic       nxt_rd_i,
  output logic       we_no,
  output logic       oe_no,
  output logic [1:0] dsack_no,
  output logic       dsack_oe_o
);
  logic strobe_ph;
  assign strobe_ph = (nxt_i == ST_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_no      <= 1'b1;
      oe_no      <= 1'b1;
      dsack_no   <= 2'b11;
      dsack_oe_o <= 1'b0;
    end else begin
      we_no      <= !(strobe_ph && !nxt_rd_i);
      // read enable holds through the acknowledge
      oe_no      <= !((strobe_ph || nxt_i == ST_ACK) && nxt_rd_i);
      dsack_no   <= (nxt_i == ST_ACK) ? 2'b00 : 2'b11;
      dsack_oe_o <= (nxt_i == ST_ACK) || (nxt_i == ST_PRECHG);
    end
  end

  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));

  p_ack_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsack_oe_o |-> (dsack_no == 2'b00 || dsack_no == 2'b11));

  p_ack_we_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsack_oe_o && dsack_no == 2'b00) |-> we_no);

  p_prechg_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsack_oe_o && dsack_no == 2'b11) |=> !dsack_oe_o);
endmodule

// File: rtl/flash_strobe_if.sv
module flash_strobe_if
  import flash_strobe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_STATES = 0,
  parameter int MIN_WE_CLKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       as_ni,
  input  logic       ds_ni,
  input  logic       rw_i,
  input  logic       sel_i,
  output logic       we_no,
  output logic       oe_no,
  output logic [1:0] dsack_no,
  output logic       dsack_oe_o
);
  localparam int N_IN = 4;

  logic [N_IN-1:0] raw, syn;
  logic as_s, ds_s, rw_s, sel_s;
  cyc_st_e st, nxt;
  logic nxt_rd;

  assign raw = {!as_ni, !ds_ni, rw_i, sel_i};
  assign {as_s, ds_s, rw_s, sel_s} = syn;

  fs_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  fs_cycle_fsm #(.WAIT_STATES(WAIT_STATES), .MIN_WE_CLKS(MIN_WE_CLKS)) u_fsm (
    .clk_i, .rst_ni,
    .as_i(as_s), .ds_i(ds_s), .rw_i(rw_s), .sel_i(sel_s),
    .st_o(st), .nxt_o(nxt), .nxt_rd_o(nxt_rd)
  );

  fs_strobe_out u_out (
    .clk_i, .rst_ni, .nxt_i(nxt), .nxt_rd_i(nxt_rd),
    .we_no, .oe_no, .dsack_no, .dsack_oe_o
  );

  p_we_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> ($past(as_s) && $past(st) == ST_IDLE));

  p_we_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> ((dsack_oe_o && dsack_no == 2'b00) || !$past(as_s)));
endmodule

// File: tb/sim_flash_strobe_if.sv
`timescale 1ns/1ps
module sim_flash_strobe_if;
  localparam int WS   = 4;
  localparam int MINC = 8;
  localparam real TCK = 8.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, ds_n = 1'b1, rw = 1'b1, sel = 1'b0;
  logic we_no, oe_no, dsack_oe;
  logic [1:0] dsack_no;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  realtime t_fall = 0, t_rise = 0, t_ds = 0, t_off = 0;

  always #(TCK/2) clk = !clk;

  flash_strobe_if #(.WAIT_STATES(WS), .MIN_WE_CLKS(MINC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .as_ni(as_n), .ds_ni(ds_n), .rw_i(rw),
    .sel_i(sel), .we_no(we_no), .oe_no(oe_no), .dsack_no(dsack_no),
    .dsack_oe_o(dsack_oe)
  );

  always @(negedge we_no) t_fall = $realtime;
  always @(posedge we_no) t_rise = $realtime;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $realtime);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // R2 mutual exclusion on every sample after reset
  always @(negedge clk)
    if (rst_n) chk(!(!we_no && !oe_no), "R2 exclusive strobes", {30'b0, we_no, oe_no}, 1);

  task automatic selected_cycle(input bit rd, input int d);
    int p = (d + WS > MINC) ? d + WS : MINC;
    bit acked = 1'b0;
    @(negedge clk);
    as_n = 1'b0; rw = rd; sel = 1'b1; ds_n = 1'b1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n == 2) chk(we_no && oe_no, "R3 not early", {30'b0, we_no, oe_no}, 3);
      if (n == 3) begin
        if (rd) chk(!oe_no && we_no, "R3 read strobe at third edge", {30'b0, we_no, oe_no}, 2);
        else    chk(!we_no && oe_no, "R3 write strobe at third edge", {30'b0, we_no, oe_no}, 1);
      end
      if (dsack_oe && dsack_no == 2'b00) begin
        chk(n == 3 + p, "R4 strobe length", n, 3 + p);
        chk(n == 3 + p, "R6 ack edge", n, 3 + p);
        acked = 1'b1;
        break;
      end
      if (n == d) begin ds_n = 1'b0; t_ds = $realtime; end
    end
    if (!acked) chk(1'b0, "R6 no ack", 0, 1);
    if (rd) chk(!oe_no, "R9 oe held at ack", oe_no, 0);
    else begin
      chk(we_no, "R4 we high at ack", we_no, 1);
      chk(int'(t_rise - t_fall) == p * 8, "R4 pulse ns", int'(t_rise - t_fall), p * 8);
      chk(t_rise - t_fall >= 60.0, "R5 pulse >= 60", int'(t_rise - t_fall), 60);
      chk(t_rise - t_ds >= 50.0, "R5 setup >= 50", int'(t_rise - t_ds), 50);
    end
    for (int k = 1; k <= 2; k++) begin
      @(negedge clk);
      chk(dsack_oe && dsack_no == 2'b00, "R6 ack held", {29'b0, dsack_oe, dsack_no}, 4);
    end
    as_n = 1'b1; ds_n = 1'b1; t_off = $realtime;
    if (!rd) begin
      chk(t_off - t_rise >= 10.0, "R5 hold >= 10", int'(t_off - t_rise), 10);
      chk(t_off - t_fall >= 50.0, "R5 addr hold >= 50", int'(t_off - t_fall), 50);
    end
    for (int m = 1; m <= 4; m++) begin
      @(negedge clk);
      if (m <= 2) begin
        chk(dsack_oe && dsack_no == 2'b00, "R6 ack until as seen", {29'b0, dsack_oe, dsack_no}, 4);
        if (rd) chk(!oe_no, "R9 oe low until as seen", oe_no, 0);
      end else if (m == 3) begin
        chk(dsack_oe && dsack_no == 2'b11, "R7 precharge", {29'b0, dsack_oe, dsack_no}, 7);
        chk(oe_no && we_no, "R9 strobes high at precharge", {30'b0, we_no, oe_no}, 3);
      end else
        chk(!dsack_oe, "R7 release", dsack_oe, 0);
    end
    sel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic unselected_cycle(input bit rd);
    @(negedge clk);
    as_n = 1'b0; rw = rd; sel = 1'b0;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (n == 1) ds_n = 1'b0;
      chk(we_no && oe_no && !dsack_oe, "R1 unselected ignored", {29'b0, we_no, oe_no, dsack_oe}, 6);
    end
    as_n = 1'b1; ds_n = 1'b1;
    for (int m = 1; m <= 4; m++) begin
      @(negedge clk);
      chk(we_no && oe_no && !dsack_oe, "R1 unselected end", {29'b0, we_no, oe_no, dsack_oe}, 6);
    end
  endtask

  task automatic abort_cycle(input bit rd);
    @(negedge clk);
    as_n = 1'b0; rw = rd; sel = 1'b1; ds_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd ? !oe_no : !we_no, "R8 strobe low before abort", rd ? oe_no : we_no, 0);
    as_n = 1'b1;
    for (int m = 1; m <= 4; m++) begin
      @(negedge clk);
      if (m <= 2)
        chk((rd ? !oe_no : !we_no) && !dsack_oe, "R8 strobe holds until as seen", {30'b0, we_no, oe_no}, rd ? 2 : 1);
      else if (m == 3) begin
        chk(we_no && oe_no, "R8 strobe released", {30'b0, we_no, oe_no}, 3);
        chk(dsack_oe && dsack_no == 2'b11, "R8 precharge after abort", {29'b0, dsack_oe, dsack_no}, 7);
      end else
        chk(!dsack_oe, "R7 release after abort", dsack_oe, 0);
    end
    sel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(we_no && oe_no && !dsack_oe, "R10 reset state", {29'b0, we_no, oe_no, dsack_oe}, 6);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int d = 1; d <= 10; d++) selected_cycle(1'b0, d);
    for (int d = 1; d <= 10; d++) selected_cycle(1'b1, d);
    unselected_cycle(1'b0);
    unselected_cycle(1'b1);
    abort_cycle(1'b0);
    abort_cycle(1'b1);
    selected_cycle(1'b0, 2);
    finish_run();
  end

  initial begin
    #(TCK * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end
endmodule